// File: doc/BRIEF.md
# Phase-Accumulator SPI Serial Clock Generator

This block derives the serial clock of an SPI controller from a fixed reference clock (40 MHz by default) with a phase accumulator whose modulus is 2048. Each enabled reference cycle adds a programmable step to the accumulator. The serial clock is at its active level while the accumulator sits in the upper half of its range, and it returns to idle when the accumulator wraps. The output frequency is therefore reference × step / 2048, which gives fractional steps instead of only integer divisions. Software normally picks the step as the ceiling of 2048 divided by the ceiling of the ratio between the reference and the target frequency.

Alongside the clock, the block produces one-cycle strobes that tell a shift engine when to drive out a bit (launch) and when to sample one (latch). A clock-phase input decides which serial clock edge gets which strobe. An idle-level input inverts the clock at the output. A wrap-clear input sends the accumulator back to zero on every wrap, so each period lasts the same number of reference cycles. Without it, the remainder carries over and the periods dither to give the exact average rate.

Top module: `spi_phase_sclk_gen`

## Requirements
- R1: During reset and afterwards, until the generator is enabled, `sclk` equals `idle_high` and both strobes are 0.
- R2: Each enabled cycle with a nonzero step adds the step to a 2048-modulus accumulator. `sclk` is active (not `idle_high`) exactly while the accumulator is 1024 or more. The leading edge is the update that crosses 1024, and the trailing edge is the update that wraps. `sclk`, the strobes and the accumulator all change on the same clock edge.
- R3: A step of 1024 or more acts as 1024. `sclk` then changes level on every enabled cycle, which is half the reference rate.
- R4: A step of 0 holds `sclk` at `idle_high` and keeps both strobes at 0, even when `gen_en` is 1.
- R5: While `gen_en` is 0, the accumulator is held at zero. After `gen_en` rises, the first leading edge occurs on the ceil(1024/step)-th enabled cycle.
- R6: With `wrap_clear` = 1, the accumulator goes to 0 on each wrap, and the period is ceil(2048/step) cycles. With `wrap_clear` = 0, the remainder is kept, and N enabled cycles from zero contain floor(N·step/2048) trailing edges.
- R7: `idle_high` = 1 inverts `sclk`, so the idle level is high and the active level is low.
- R8: With `lead_launch` = 0, `latch_stb` pulses for one cycle with each leading edge and `launch_stb` with each trailing edge. With `lead_launch` = 1, the two are swapped. The two strobes are never high together.
- R9: If `gen_en` falls in the cycle before an edge is due, disable wins. No strobe is issued, and `sclk` shows its idle level on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Run the accumulator; when low, hold it at zero |
| step_inc | input | INC_W | Phase step added each cycle (12 bits by default) |
| wrap_clear | input | 1 | Clear the accumulator on every wrap |
| idle_high | input | 1 | Idle level of the serial clock |
| lead_launch | input | 1 | 1: launch on the leading edge, latch on the trailing edge |
| sclk | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle strobe to drive the next bit |
| latch_stb | output | 1 | One-cycle strobe to sample the incoming bit |

## Verification
Turning the generator off and a scheduled clock edge can land in the same cycle. The bench provokes this by running at the fastest step and dropping `gen_en` in exactly the cycle before a leading edge is due. It then checks on the next cycle that `sclk` is idle and that neither strobe fired. Wrap and wrap-clear also coincide on every period. The bench compares the count of trailing edges over a fixed window with the clear set and with it cleared, where the two counts differ.

// File: rtl/spi_phase_pkg.sv
package spi_phase_pkg;
   // Edge events produced by the accumulator in one update
   typedef struct packed {
      logic lead;   // crossed into the upper half
      logic trail;  // wrapped past the modulus
   } edge_ev_t;
endpackage

// File: rtl/phase_inc_clamp.sv
module phase_inc_clamp #(
   parameter int ACC_W = 11,
   parameter int INC_W = 12
) (
   input  logic [INC_W-1:0] step_inc,
   output logic [ACC_W-1:0] eff_inc,
   output logic             inc_zero
);
   localparam int HALF = 1 << (ACC_W - 1);

   if (INC_W < ACC_W) begin : g_bad_width
      $error("phase_inc_clamp: INC_W must be at least ACC_W");
   end

   always_comb begin
      inc_zero = (step_inc == '0);
      if (step_inc >= INC_W'(HALF))
         eff_inc = ACC_W'(HALF);
      else
         eff_inc = step_inc[ACC_W-1:0];
   end

   always_comb begin
      assert_clamp_bound_R3: assert (eff_inc <= ACC_W'(HALF) || $isunknown(step_inc));
   end
endmodule

// File: rtl/phase_accum.sv
module phase_accum
   import spi_phase_pkg::*;
#(
   parameter int ACC_W     = 11,
   parameter bit CLEAR_OPT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [ACC_W-1:0] eff_inc,
   input  logic             wrap_clear,
   output logic             phase_hi,
   output edge_ev_t         ev
);
   logic [ACC_W-1:0] acc;
   logic [ACC_W:0]   sum;
   logic             wrap;
   logic             lead_n;
   logic             clear_eff;
   logic [ACC_W-1:0] acc_next;

   if (CLEAR_OPT) begin : g_clear
      assign clear_eff = wrap_clear;
   end else begin : g_no_clear
      assign clear_eff = 1'b0;
   end

   always_comb begin
      sum      = {1'b0, acc} + {1'b0, eff_inc};
      wrap     = sum[ACC_W];
      lead_n   = !acc[ACC_W-1] && sum[ACC_W-1] && !wrap;
      acc_next = (wrap && clear_eff) ? '0 : sum[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
         ev  <= '0;
      end else if (!run) begin
         acc <= '0;
         ev  <= '0;
      end else begin
         acc      <= acc_next;
         ev.lead  <= lead_n;
         ev.trail <= wrap;
      end
   end

   assign phase_hi = acc[ACC_W-1];

   assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (acc == '0 && ev == '0));
   assert_lead_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev.lead |-> (phase_hi && !$past(phase_hi)));
   assert_trail_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev.trail |-> (!phase_hi && $past(phase_hi)));
   assert_clear_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.trail && $past(clear_eff)) |-> (acc == '0));
endmodule

// File: rtl/phase_edge_out.sv
module phase_edge_out
   import spi_phase_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     phase_hi,
   input  edge_ev_t ev,
   input  logic     idle_high,
   input  logic     lead_launch,
   output logic     sclk,
   output logic     launch_stb,
   output logic     latch_stb
);
   always_comb begin
      sclk       = phase_hi ^ idle_high;
      launch_stb = lead_launch ? ev.lead  : ev.trail;
      latch_stb  = lead_launch ? ev.trail : ev.lead;
   end

   assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(launch_stb && latch_stb));
endmodule

// File: rtl/spi_phase_sclk_gen.sv
module spi_phase_sclk_gen
   import spi_phase_pkg::*;
#(
   parameter int ACC_W     = 11,
   parameter int INC_W     = 12,
   parameter bit CLEAR_OPT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gen_en,
   input  logic [INC_W-1:0] step_inc,
   input  logic             wrap_clear,
   input  logic             idle_high,
   input  logic             lead_launch,
   output logic             sclk,
   output logic             launch_stb,
   output logic             latch_stb
);
   localparam int HALF = 1 << (ACC_W - 1);

   if (ACC_W < 2) begin : g_bad_acc
      $error("spi_phase_sclk_gen: ACC_W must be at least 2");
   end

   logic [ACC_W-1:0] eff_inc;
   logic             inc_zero;
   logic             run;
   logic             phase_hi;
   edge_ev_t         ev;

   phase_inc_clamp #(.ACC_W(ACC_W), .INC_W(INC_W)) u_clamp (
      .step_inc (step_inc),
      .eff_inc  (eff_inc),
      .inc_zero (inc_zero)
   );

   assign run = gen_en && !inc_zero;

   phase_accum #(.ACC_W(ACC_W), .CLEAR_OPT(CLEAR_OPT)) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .eff_inc    (eff_inc),
      .wrap_clear (wrap_clear),
      .phase_hi   (phase_hi),
      .ev         (ev)
   );

   phase_edge_out u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase_hi    (phase_hi),
      .ev          (ev),
      .idle_high   (idle_high),
      .lead_launch (lead_launch),
      .sclk        (sclk),
      .launch_stb  (launch_stb),
      .latch_stb   (latch_stb)
   );

   assert_fast_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_en && step_inc >= INC_W'(HALF)) |=> ((sclk ^ idle_high) != $past(sclk ^ idle_high)));
   assert_zero_step_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_inc == '0) |=> (sclk == idle_high && !launch_stb && !latch_stb));
   assert_idle_after_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |=> (sclk == idle_high && !launch_stb && !latch_stb));
endmodule

// File: tb/sim_spi_phase_sclk_gen.sv
module sim_spi_phase_sclk_gen;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 7;
   // step, clear, first leading cycle, period, active cycles
   localparam int V_INC  [NV] = '{512, 256, 1024, 2000, 768, 400, 1024};
   localparam int V_CLR  [NV] = '{0,   1,   0,    0,    1,   1,   1};
   localparam int V_FIRST[NV] = '{2,   4,   1,    1,    2,   3,   1};
   localparam int V_PER  [NV] = '{4,   8,   2,    2,    3,   6,   2};
   localparam int V_HI   [NV] = '{2,   4,   1,    1,    1,   3,   1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gen_en = 1'b0;
   logic [11:0] step_inc = '0;
   logic wrap_clear = 1'b0;
   logic idle_high = 1'b0;
   logic lead_launch = 1'b0;
   logic sclk, launch_stb, latch_stb;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_phase_sclk_gen u0 (
      .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .step_inc(step_inc),
      .wrap_clear(wrap_clear), .idle_high(idle_high), .lead_launch(lead_launch),
      .sclk(sclk), .launch_stb(launch_stb), .latch_stb(latch_stb)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic go_off();
      gen_en = 1'b0;
      tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
      chk(!launch_stb && !latch_stb, "R1", "strobes in reset", launch_stb + latch_stb, 0);
      rst_n = 1'b1;
      tick();
      chk(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);

      // Table of rates walked by one loop (R2, R3, R5, R6, R8)
      for (int v = 0; v < NV; v++) begin
         go_off();
         step_inc = 12'(V_INC[v]);
         wrap_clear = V_CLR[v][0];
         gen_en = 1'b1;
         for (int k = 1; k <= V_FIRST[v] + 2 * V_PER[v]; k++) begin
            int ph;
            bit e_hi, e_lead, e_trail;
            tick();
            ph = k - V_FIRST[v];
            e_hi    = (ph >= 0) && ((ph % V_PER[v]) < V_HI[v]);
            e_lead  = (ph >= 0) && ((ph % V_PER[v]) == 0);
            e_trail = (ph >= 0) && ((ph % V_PER[v]) == V_HI[v]);
            chk(sclk == e_hi, "R2/R3/R6", $sformatf("vec%0d k%0d sclk", v, k), sclk, e_hi);
            chk(latch_stb == e_lead, "R8", $sformatf("vec%0d k%0d latch", v, k), latch_stb, e_lead);
            chk(launch_stb == e_trail, "R8", $sformatf("vec%0d k%0d launch", v, k), launch_stb, e_trail);
         end
      end

      // R4: zero step keeps idle
      go_off();
      step_inc = '0;
      gen_en = 1'b1;
      for (int k = 0; k < 10; k++) begin
         tick();
         chk(sclk == 1'b0 && !launch_stb && !latch_stb, "R4", "zero step idle",
             sclk + launch_stb + latch_stb, 0);
      end

      // R6: carried remainder versus clear-on-wrap, trailing counts over 24 cycles
      for (int c = 0; c < 2; c++) begin
         int n;
         go_off();
         step_inc = 12'd768;
         wrap_clear = c[0];
         gen_en = 1'b1;
         n = 0;
         for (int k = 0; k < 24; k++) begin
            tick();
            if (launch_stb) n++;
         end
         chk(n == (c == 0 ? 9 : 8), "R6", "trailing edges in 24 cycles", n, (c == 0 ? 9 : 8));
      end

      // R7: inverted idle level
      go_off();
      idle_high = 1'b1;
      wrap_clear = 1'b0;
      step_inc = 12'd512;
      tick();
      chk(sclk == 1'b1, "R7", "idle high while off", sclk, 1);
      gen_en = 1'b1;
      tick(); tick();
      chk(sclk == 1'b0, "R7", "active low at k2", sclk, 0);
      tick(); tick();
      chk(sclk == 1'b1, "R7", "idle high at k4", sclk, 1);
      idle_high = 1'b0;

      // R8: swapped strobes
      go_off();
      lead_launch = 1'b1;
      step_inc = 12'd512;
      gen_en = 1'b1;
      tick();
      tick();
      chk(launch_stb == 1'b1 && latch_stb == 1'b0, "R8", "launch on leading edge",
          {launch_stb, latch_stb}, 2);
      tick();
      tick();
      chk(latch_stb == 1'b1 && launch_stb == 1'b0, "R8", "latch on trailing edge",
          {launch_stb, latch_stb}, 1);
      lead_launch = 1'b0;

      // R5: re-enable restarts from zero phase
      go_off();
      step_inc = 12'd768;
      gen_en = 1'b1;
      for (int k = 0; k < 5; k++) tick();
      chk(sclk == 1'b1, "R5", "active before disable", sclk, 1);
      gen_en = 1'b0;
      tick();
      chk(sclk == 1'b0, "R5", "idle after disable", sclk, 0);
      gen_en = 1'b1;
      tick();
      chk(sclk == 1'b0 && !latch_stb, "R5", "no edge first cycle", sclk + latch_stb, 0);
      tick();
      chk(sclk == 1'b1 && latch_stb, "R5", "leading edge second cycle", sclk + latch_stb, 2);

      // R9: disable lands where a leading edge is due
      go_off();
      step_inc = 12'd1024;
      gen_en = 1'b1;
      tick();
      tick();
      chk(sclk == 1'b0, "R9", "low before due edge", sclk, 0);
      gen_en = 1'b0;
      tick();
      chk(sclk == 1'b0 && !latch_stb && !launch_stb, "R9", "disable beats edge",
          sclk + latch_stb + launch_stb, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule